// File: doc/BRIEF.md
# Three-Pass Shared-Multiplier 32-bit Product Unit

This block multiplies two unsigned 32-bit operands using a single signed 17x17 multiplier that it reuses on three consecutive cycles. Each operand is cut into a 16-bit upper half and a 16-bit lower half. The three narrow products are lower×lower, upper×upper, and the product of two half-differences. The unit accumulates a middle term from these products and then merges everything with one shift-and-add step. Four multiplies are replaced by three, at the cost of a few additions.

A caller pulses `start_i` with both operands and a mode bit. The unit stays busy for four cycles: three multiply steps and one merge. It then raises `done_o` for one cycle. The result register holds its value until the next operation completes. Mode 0 returns the full 64-bit product. Mode 1 returns only the lower 32 bits, zero-extended, and computes that merge with 32-bit additions only.

Top module: `kmul_top`

## Requirements
- R1: While and directly after a synchronous reset, `busy_o` is 0, `done_o` is 0 and `product_o` is 0.
- R2: A `start_i` sampled high at a rising edge while `busy_o` is 0 makes `busy_o` high for exactly the four following cycles.
- R3: `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls, and never while `busy_o` is high.
- R4: With `mode_i` = 0 at start, the `product_o` shown with `done_o` equals the unsigned 64-bit product of the two operands.
- R5: With `mode_i` = 1 at start, `product_o[31:0]` equals the lower 32 bits of the unsigned product and `product_o[63:32]` is 0.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its timing and its result.
- R7: `product_o` does not change except in the cycle where `done_o` rises.
- R8: The operands and the mode are captured at the accepted start. Changes on `opa_i`, `opb_i` or `mode_i` during the busy cycles do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| opa_i | input | 32 | First unsigned operand |
| opb_i | input | 32 | Second unsigned operand |
| mode_i | input | 1 | 0 = full 64-bit product, 1 = lower 32 bits only |
| busy_o | output | 1 | High during the four working cycles |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| product_o | output | 64 | Result register |

## Verification
Take an accepted start sampled at edge E. `busy_o` is high from E to E+4. `done_o` and the new `product_o` appear after edge E+4 and last one cycle; the product then holds. The bench keeps a reference model that counts down four edges from each accepted start and computes the expected product arithmetically. It compares every output against this model on every falling edge, so each result is checked in exactly the cycle it is due and in no other. Corner operands exercise the largest half-differences of either sign: zero, all ones, equal halves, and one half zero with the other all ones.

// File: rtl/kmul_pkg.sv
package kmul_pkg;

    localparam int HALF_W   = 16;
    localparam int OP_W     = 2 * HALF_W;
    localparam int SH_W     = HALF_W + 1;
    localparam int MP_W     = 2 * SH_W;
    localparam int ACC_W    = OP_W + 4;
    localparam int RES_W    = 2 * OP_W;
    localparam int BUSY_LEN = 4;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_LOW  = 1'b1
    } kmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL,
        ST_HH,
        ST_DD,
        ST_FIN
    } kstate_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } halves_t;

    typedef struct packed {
        halves_t                  a;
        halves_t                  b;
        logic signed [SH_W-1:0]   da;
        logic signed [SH_W-1:0]   db;
    } opsplit_t;

    function automatic logic signed [SH_W-1:0] half_diff(
        input logic [HALF_W-1:0] minuend,
        input logic [HALF_W-1:0] subtrahend
    );
        return $signed({1'b0, minuend}) - $signed({1'b0, subtrahend});
    endfunction

    function automatic logic signed [SH_W-1:0] widen_half(input logic [HALF_W-1:0] h);
        return $signed({1'b0, h});
    endfunction

endpackage

// File: rtl/kmul_split.sv
module kmul_split
    import kmul_pkg::*;
(
    input  logic [OP_W-1:0] opa,
    input  logic [OP_W-1:0] opb,
    output opsplit_t        parts
);
    always_comb begin
        parts.a.hi = opa[OP_W-1:HALF_W];
        parts.a.lo = opa[HALF_W-1:0];
        parts.b.hi = opb[OP_W-1:HALF_W];
        parts.b.lo = opb[HALF_W-1:0];
        // lower-minus-upper on A, upper-minus-lower on B: product enters the middle term with + sign
        parts.da   = half_diff(opa[HALF_W-1:0], opa[OP_W-1:HALF_W]);
        parts.db   = half_diff(opb[OP_W-1:HALF_W], opb[HALF_W-1:0]);
    end
endmodule

// File: rtl/kmul_shared_mult.sv
module kmul_shared_mult
    import kmul_pkg::*;
(
    input  kstate_e                 step,
    input  opsplit_t                parts,
    output logic signed [MP_W-1:0]  prod
);
    logic signed [SH_W-1:0] mx;
    logic signed [SH_W-1:0] my;

    always_comb begin
        unique case (step)
            ST_LL: begin
                mx = widen_half(parts.a.lo);
                my = widen_half(parts.b.lo);
            end
            ST_HH: begin
                mx = widen_half(parts.a.hi);
                my = widen_half(parts.b.hi);
            end
            ST_DD: begin
                mx = parts.da;
                my = parts.db;
            end
            default: begin
                mx = '0;
                my = '0;
            end
        endcase
    end

    assign prod = MP_W'(mx) * MP_W'(my);
endmodule

// File: rtl/kmul_ctrl.sv
module kmul_ctrl
    import kmul_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output kstate_e step,
    output logic    accept,
    output logic    busy,
    output logic    done
);
    kstate_e state_q;
    kstate_e state_d;
    logic    done_q;

    assign accept = start && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LL;
            ST_LL:   state_d = ST_HH;
            ST_HH:   state_d = ST_DD;
            ST_DD:   state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FIN);
        end
    end

    assign step = state_q;
    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
endmodule

// File: rtl/kmul_combine.sv
module kmul_combine
    import kmul_pkg::*;
(
    input  kmode_e                  mode,
    input  logic [OP_W-1:0]         ll,
    input  logic [OP_W-1:0]         hh,
    input  logic signed [ACC_W-1:0] mid,
    output logic [RES_W-1:0]        result
);
    logic [RES_W-1:0] mid_wide;
    logic [RES_W-1:0] full_sum;
    logic [OP_W-1:0]  low_sum;

    assign mid_wide = RES_W'($unsigned({{(RES_W-ACC_W){mid[ACC_W-1]}}, mid}));
    assign full_sum = {{OP_W{1'b0}}, ll} + (mid_wide << HALF_W) + {hh, {OP_W{1'b0}}};
    // narrow path: only OP_W-bit adds are needed for the truncated product
    assign low_sum  = ll + (mid[OP_W-1:0] << HALF_W);

    always_comb begin
        if (mode == MODE_LOW) result = {{OP_W{1'b0}}, low_sum};
        else                  result = full_sum;
    end
endmodule

// File: rtl/kmul_top.sv
module kmul_top
    import kmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [31:0]      opa_i,
    input  logic [31:0]      opb_i,
    input  logic             mode_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [63:0]      product_o
);
    kstate_e                  step;
    logic                     accept;
    logic                     busy;
    logic                     done;
    logic [OP_W-1:0]          opa_q;
    logic [OP_W-1:0]          opb_q;
    kmode_e                   mode_q;
    opsplit_t                 parts;
    logic signed [MP_W-1:0]   prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic [OP_W-1:0]          ll_q;
    logic [OP_W-1:0]          hh_q;
    logic signed [ACC_W-1:0]  mid_q;
    logic [RES_W-1:0]         merged;
    logic [RES_W-1:0]         product_q;

    kmul_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .step   (step),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q  <= '0;
            opb_q  <= '0;
            mode_q <= MODE_FULL;
        end else if (accept) begin
            opa_q  <= opa_i;
            opb_q  <= opb_i;
            mode_q <= kmode_e'(mode_i);
        end
    end

    kmul_split u_split (
        .opa   (opa_q),
        .opb   (opb_q),
        .parts (parts)
    );

    kmul_shared_mult u_mult (
        .step  (step),
        .parts (parts),
        .prod  (prod)
    );

    assign prod_ext = {{(ACC_W-MP_W){prod[MP_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            ll_q  <= '0;
            hh_q  <= '0;
            mid_q <= '0;
        end else begin
            unique case (step)
                ST_LL: begin
                    ll_q  <= prod[OP_W-1:0];
                    mid_q <= prod_ext;
                end
                ST_HH: begin
                    hh_q  <= prod[OP_W-1:0];
                    mid_q <= mid_q + prod_ext;
                end
                ST_DD:   mid_q <= mid_q + prod_ext;
                default: ;
            endcase
        end
    end

    kmul_combine u_comb (
        .mode   (mode_q),
        .ll     (ll_q),
        .hh     (hh_q),
        .mid    (mid_q),
        .result (merged)
    );

    always_ff @(posedge clk) begin
        if (rst)                product_q <= '0;
        else if (step == ST_FIN) product_q <= merged;
    end

    assign busy_o    = busy;
    assign done_o    = done;
    assign product_o = product_q;
endmodule

// File: rtl/kmul_chk.sv
module kmul_chk
    import kmul_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [63:0]     product_o,
    input logic [OP_W-1:0] opa_q,
    input logic [OP_W-1:0] opb_q,
    input kmode_e          mode_q
);
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= '0;
        else if (busy_o) run_q <= run_q + 4'd1;
        else             run_q <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy_o && !done_o && product_o == '0)); // R1
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o) |=> busy_o); // R2
    AST_BUSY_MAX_LEN: assert property (@(posedge clk) disable iff (rst) busy_o |-> (run_q < 4'(BUSY_LEN))); // R2
    AST_BUSY_EXACT_LEN: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> (run_q == 4'(BUSY_LEN))); // R2
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> done_o); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) done_o |-> !busy_o); // R3
    AST_FULL_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_q == MODE_FULL) |-> (product_o == {{OP_W{1'b0}}, opa_q} * {{OP_W{1'b0}}, opb_q})); // R4
    AST_LOW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_q == MODE_LOW) |-> (product_o[63:32] == '0)); // R5
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst) !done_o |-> $stable(product_o)); // R7
endmodule

bind kmul_top kmul_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o),
    .opa_q     (opa_q),
    .opb_q     (opb_q),
    .mode_q    (mode_q)
);

// File: tb/kmul_top_tb.sv
module kmul_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        mode_i = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic [63:0] product_o;

    int checks = 0;
    int errors = 0;
    string tag = "R4";

    always #10 clk = ~clk;

    kmul_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .mode_i    (mode_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    // behavioural reference: countdown per accepted start, arithmetic result
    int          m_cnt = 0;
    logic        m_done = 1'b0;
    logic [63:0] m_prod = '0;
    logic [63:0] m_pend = '0;

    function automatic logic [63:0] expect_of(input logic [31:0] a, input logic [31:0] b, input logic m);
        logic [63:0] full;
        full = {32'b0, a} * {32'b0, b};
        return m ? {32'b0, full[31:0]} : full;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_done = 1'b0; m_prod = '0;
        end else begin
            m_done = 1'b0;
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_done = 1'b1;
                    m_prod = m_pend;
                end
            end else if (start_i) begin
                m_cnt  = 4;
                m_pend = expect_of(opa_i, opb_i, mode_i);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (busy_o !== (m_cnt > 0)) begin
                errors++;
                $display("FAIL R2 busy: actual %b expected %b", busy_o, (m_cnt > 0));
            end
            checks++;
            if (done_o !== m_done) begin
                errors++;
                $display("FAIL R3 done: actual %b expected %b", done_o, m_done);
            end
            checks++;
            if (product_o !== m_prod) begin
                errors++;
                $display("FAIL %s product: actual %h expected %h", tag, product_o, m_prod);
            end
        end
    end

    task automatic launch(input logic [31:0] a, input logic [31:0] b, input logic m);
        @(posedge clk); #2;
        opa_i = a; opb_i = b; mode_i = m; start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic m);
        launch(a, b, m);
        repeat (5) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] corners [6];
        corners[0] = 32'h0000_0000;
        corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h1234_1234;
        corners[3] = 32'hFFFF_0000;
        corners[4] = 32'h0000_FFFF;
        corners[5] = 32'h8000_0001;

        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (busy_o !== 1'b0 || done_o !== 1'b0 || product_o !== 64'd0) begin
            errors++;
            $display("FAIL R1 reset: actual busy=%b done=%b prod=%h expected 0 0 0", busy_o, done_o, product_o);
        end

        // R4 / R5: corner pairs in both modes
        for (int m = 0; m < 2; m++) begin
            tag = (m == 0) ? "R4" : "R5";
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    run_op(corners[i], corners[j], m[0]);
        end

        // R4 / R5: random operands
        for (int k = 0; k < 300; k++) begin
            logic m;
            m = k[0];
            tag = m ? "R5" : "R4";
            run_op($urandom, $urandom, m);
        end

        // R6: start pulses while busy are ignored
        tag = "R6";
        for (int k = 0; k < 10; k++) begin
            launch($urandom, $urandom, k[0]);
            @(posedge clk); #2;
            opa_i = $urandom; opb_i = $urandom; mode_i = ~mode_i; start_i = 1'b1;
            @(posedge clk); #2;
            start_i = 1'b0;
            repeat (4) @(posedge clk);
        end

        // R8: operand and mode inputs wiggle during busy
        tag = "R8";
        for (int k = 0; k < 10; k++) begin
            launch($urandom, $urandom, k[0]);
            for (int c = 0; c < 3; c++) begin
                @(posedge clk); #2;
                opa_i = $urandom; opb_i = $urandom; mode_i = $urandom;
            end
            repeat (3) @(posedge clk);
        end

        // back-to-back: new start in the done cycle
        tag = "R4";
        for (int k = 0; k < 10; k++) begin
            launch($urandom, $urandom, 1'b0);
            repeat (3) @(posedge clk);
        end
        repeat (5) @(posedge clk);

        // R7: idle with moving inputs, result must hold
        tag = "R7";
        for (int c = 0; c < 20; c++) begin
            @(posedge clk); #2;
            opa_i = $urandom; opb_i = $urandom; mode_i = $urandom;
        end
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule